// File: doc/BRIEF.md
# SR-IOV Capability Register Block

This block holds the control and status words of a single-root I/O virtualization extended capability. Configuration software reaches it through a 32-bit, byte-enabled write port and a separate read port. Both ports take a byte offset measured from the capability base. The block keeps the control word, the active virtual-function count and the system page size as writable state. It returns the initial and total function counts, the routing offset and stride, the virtual-function device ID and the supported page-size set as fixed values.

The block checks each write against its own rules. Only three control bits can be written. Any write to the active count turns virtual functions off. An enable request is refused while the requested count is above the total. The writable bits of the system page size follow the supported page-size set, and that set can be widened from an input. Downstream function logic receives one-cycle pulses when functions are switched on or off, together with an effective count that is zero while functions are disabled.

Top module: `sriov_cap_regs`

## Requirements
- R1: In the control word (dword at offset 0x08, bits 15:0), only bit 0 (function enable), bit 3 (function memory enable) and bit 4 (hierarchy ARI-capable) take written values. Every other bit of that dword, including the status half in bits 31:16, reads as zero. A control write needs byte lane 0 enabled.
- R2: The active function count (offset 0x10, bits 15:0) is writable on all 16 bits, one byte lane per byte. Bits 31:16 of that dword read as zero.
- R3: After reset the control word is 0, the active count is 0 and the system page size (offset 0x20) is 0x00000001. The enable output, both pulses and the effective count are 0.
- R4: The writable bits of the system page size equal the supported set, 0x553 ORed with the extra_pgsz input. The supported set reads at offset 0x1C. Bits outside that set keep their value.
- R5: A write with byte lane 0 or 1 enabled at offset 0x10 clears function enable in the same cycle that it updates the count.
- R6: A control write that sets function enable while the stored active count is greater than TOTAL_VFS leaves enable cleared. With a count equal to TOTAL_VFS the enable is accepted.
- R7: eff_vfs equals the active count while function enable is set, and 0 otherwise.
- R8: A write whose offset is CAP_BYTES (0x40) or more changes no state, even when its low address bits match a register.
- R9: The fixed words read as follows, and writes to them have no effect: {TOTAL_VFS, INIT_VFS} at 0x0C, {VF_STRIDE, VF_FIRST} at 0x14, {VF_DEV_ID, 16'h0} at 0x18, and the supported set at 0x1C. Read data appears one cycle after rd_off. Unlisted offsets and offsets of CAP_BYTES or more read as 0.
- R10: vf_on_pulse is high for exactly the first cycle in which enable reads 1 after reading 0. vf_off_pulse is high for exactly the first cycle in which enable reads 0 after reading 1. The two are never high together.
- R11: Byte lanes that are disabled leave their bytes unchanged. A write to offset 0x08 with lane 0 disabled does not affect the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_off | input | OFF_W | Write byte offset from capability base |
| wr_be | input | 4 | Write byte-lane enables |
| wr_data | input | 32 | Write data |
| rd_off | input | OFF_W | Read byte offset from capability base |
| rd_data | output | 32 | Registered read data |
| extra_pgsz | input | 32 | Additional supported page-size bits |
| vf_enable | output | 1 | Function enable control bit |
| vf_mem_enable | output | 1 | Function memory enable control bit |
| ari_hier | output | 1 | ARI-capable hierarchy control bit |
| eff_vfs | output | 16 | Effective function count |
| vf_on_pulse | output | 1 | One-cycle pulse when functions turn on |
| vf_off_pulse | output | 1 | One-cycle pulse when functions turn off |

## Verification
The bench uses the default parameters: a total of 8 functions, 4 initial, first offset 0x80, stride 2, and 32'h2000 driven on extra_pgsz. The total is small, so random counts in 0..11 often sit just above it, just below it or exactly on it, and this exercises the enable refusal on both sides of the limit. The extra page-size bit lies outside the fixed minimum set, which shows that the writable mask follows the input. Random offsets that alias register addresses above 0x40 exercise the range check.

// File: rtl/sriov_cap_pkg.sv
package sriov_cap_pkg;

    // Dword indices inside the capability (byte offset / 4)
    localparam int DW_CTRL   = 2;
    localparam int DW_COUNTS = 3;
    localparam int DW_NUM    = 4;
    localparam int DW_ROUTE  = 5;
    localparam int DW_DID    = 6;
    localparam int DW_SUPPG  = 7;
    localparam int DW_SYSPG  = 8;

    localparam logic [7:0] CTRL_VFE   = 8'h01;
    localparam logic [7:0] CTRL_MSE   = 8'h08;
    localparam logic [7:0] CTRL_ARI   = 8'h10;
    localparam logic [7:0] CTRL_WMASK = CTRL_VFE | CTRL_MSE | CTRL_ARI;

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [15:0] num;
        logic        on_pulse;
        logic        off_pulse;
    } ctl_state_t;

    typedef struct packed {
        logic [31:0] sys;
    } pg_state_t;

    typedef struct packed {
        logic [31:0] data;
    } rd_state_t;

endpackage

// File: rtl/sriov_ctl_regs.sv
module sriov_ctl_regs
    import sriov_cap_pkg::*;
#(
    parameter int TOTAL_VFS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [7:0]  ctrl_wdata,
    input  logic        num_wr,
    input  logic [1:0]  num_be,
    input  logic [15:0] num_wdata,
    output logic [7:0]  ctrl_q,
    output logic [15:0] num_q,
    output logic        on_pulse,
    output logic        off_pulse
);
    localparam logic [15:0] TOTAL_W = 16'(TOTAL_VFS);

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.on_pulse  = 1'b0;
        st_d.off_pulse = 1'b0;
        if (ctrl_wr) begin
            st_d.ctrl = ctrl_wdata & CTRL_WMASK;
            if (st_d.ctrl[0] && (st_q.num > TOTAL_W)) begin
                st_d.ctrl[0] = 1'b0;
            end
        end else if (num_wr) begin
            if (num_be[0]) st_d.num[7:0]  = num_wdata[7:0];
            if (num_be[1]) st_d.num[15:8] = num_wdata[15:8];
            st_d.ctrl[0] = 1'b0;
        end
        st_d.on_pulse  = st_d.ctrl[0] & ~st_q.ctrl[0];
        st_d.off_pulse = ~st_d.ctrl[0] & st_q.ctrl[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_q    = st_q.ctrl;
    assign num_q     = st_q.num;
    assign on_pulse  = st_q.on_pulse;
    assign off_pulse = st_q.off_pulse;

    AST_VFE_WITHIN_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[0] |-> (num_q <= TOTAL_W)); // R6
    AST_NUM_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        num_wr |=> !ctrl_q[0]); // R5
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({on_pulse, off_pulse})); // R10
    AST_ON_PULSE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        on_pulse |-> (ctrl_q[0] && !$past(ctrl_q[0]))); // R10

endmodule

// File: rtl/sriov_pgsz_reg.sv
module sriov_pgsz_reg
    import sriov_cap_pkg::*;
#(
    parameter logic [31:0] SYS_RESET = 32'h0000_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  logic [31:0] sup_mask,
    output logic [31:0] sys_q
);
    pg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            for (int i = 0; i < 4; i++) begin
                if (be[i]) begin
                    st_d.sys[8*i +: 8] = (st_q.sys[8*i +: 8] & ~sup_mask[8*i +: 8])
                                       | (wdata[8*i +: 8] & sup_mask[8*i +: 8]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.sys <= SYS_RESET;
        else        st_q     <= st_d;
    end

    assign sys_q = st_q.sys;

    AST_SYS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sys_q) |-> (((sys_q ^ $past(sys_q)) & ~$past(sup_mask)) == 32'h0)); // R4

endmodule

// File: rtl/sriov_rd_mux.sv
module sriov_rd_mux
    import sriov_cap_pkg::*;
#(
    parameter int          OFF_W     = 12,
    parameter int          CAP_BYTES = 64,
    parameter int          INIT_VFS  = 4,
    parameter int          TOTAL_VFS = 8,
    parameter logic [15:0] VF_FIRST  = 16'h0080,
    parameter logic [15:0] VF_STRIDE = 16'h0002,
    parameter logic [15:0] VF_DEV_ID = 16'hA5C3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFF_W-1:0] rd_off,
    input  logic [7:0]       ctrl,
    input  logic [15:0]      num,
    input  logic [31:0]      sup,
    input  logic [31:0]      sys,
    output logic [31:0]      rd_data
);
    localparam int DW_W = OFF_W - 2;

    rd_state_t st_d, st_q;
    logic [DW_W-1:0] dw;

    always_comb begin
        dw        = rd_off[OFF_W-1:2];
        st_d.data = 32'h0;
        if (32'(rd_off) < CAP_BYTES) begin
            if      (dw == DW_W'(DW_CTRL))   st_d.data = {24'h0, ctrl};
            else if (dw == DW_W'(DW_COUNTS)) st_d.data = {16'(TOTAL_VFS), 16'(INIT_VFS)};
            else if (dw == DW_W'(DW_NUM))    st_d.data = {16'h0, num};
            else if (dw == DW_W'(DW_ROUTE))  st_d.data = {VF_STRIDE, VF_FIRST};
            else if (dw == DW_W'(DW_DID))    st_d.data = {VF_DEV_ID, 16'h0};
            else if (dw == DW_W'(DW_SUPPG))  st_d.data = sup;
            else if (dw == DW_W'(DW_SYSPG))  st_d.data = sys;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.data;

endmodule

// File: rtl/sriov_cap_regs.sv
module sriov_cap_regs
    import sriov_cap_pkg::*;
#(
    parameter int          OFF_W     = 12,
    parameter int          CAP_BYTES = 64,
    parameter int          INIT_VFS  = 4,
    parameter int          TOTAL_VFS = 8,
    parameter logic [15:0] VF_FIRST  = 16'h0080,
    parameter logic [15:0] VF_STRIDE = 16'h0002,
    parameter logic [15:0] VF_DEV_ID = 16'hA5C3,
    parameter logic [31:0] SUP_MIN   = 32'h0000_0553
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [3:0]       wr_be,
    input  logic [31:0]      wr_data,
    input  logic [OFF_W-1:0] rd_off,
    output logic [31:0]      rd_data,
    input  logic [31:0]      extra_pgsz,
    output logic             vf_enable,
    output logic             vf_mem_enable,
    output logic             ari_hier,
    output logic [15:0]      eff_vfs,
    output logic             vf_on_pulse,
    output logic             vf_off_pulse
);
    localparam int DW_W = OFF_W - 2;

    logic            in_range;
    logic [DW_W-1:0] wr_dw;
    logic            ctrl_wr, num_wr, sys_wr;
    logic [7:0]      ctrl_q;
    logic [15:0]     num_q;
    logic [31:0]     sup_mask, sys_q;

    always_comb begin
        in_range = wr_en && (32'(wr_off) < CAP_BYTES);
        wr_dw    = wr_off[OFF_W-1:2];
        ctrl_wr  = in_range && (wr_dw == DW_W'(DW_CTRL)) && wr_be[0];
        num_wr   = in_range && (wr_dw == DW_W'(DW_NUM)) && (wr_be[1:0] != 2'b00);
        sys_wr   = in_range && (wr_dw == DW_W'(DW_SYSPG));
        sup_mask = SUP_MIN | extra_pgsz;
    end

    sriov_ctl_regs #(.TOTAL_VFS(TOTAL_VFS)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (wr_data[7:0]),
        .num_wr     (num_wr),
        .num_be     (wr_be[1:0]),
        .num_wdata  (wr_data[15:0]),
        .ctrl_q     (ctrl_q),
        .num_q      (num_q),
        .on_pulse   (vf_on_pulse),
        .off_pulse  (vf_off_pulse)
    );

    sriov_pgsz_reg #(.SYS_RESET(32'h0000_0001)) u_pgsz (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (sys_wr),
        .be       (wr_be),
        .wdata    (wr_data),
        .sup_mask (sup_mask),
        .sys_q    (sys_q)
    );

    sriov_rd_mux #(
        .OFF_W     (OFF_W),
        .CAP_BYTES (CAP_BYTES),
        .INIT_VFS  (INIT_VFS),
        .TOTAL_VFS (TOTAL_VFS),
        .VF_FIRST  (VF_FIRST),
        .VF_STRIDE (VF_STRIDE),
        .VF_DEV_ID (VF_DEV_ID)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_off  (rd_off),
        .ctrl    (ctrl_q),
        .num     (num_q),
        .sup     (sup_mask),
        .sys     (sys_q),
        .rd_data (rd_data)
    );

    assign vf_enable     = ctrl_q[0];
    assign vf_mem_enable = ctrl_q[3];
    assign ari_hier      = ctrl_q[4];
    assign eff_vfs       = ctrl_q[0] ? num_q : 16'h0;

    AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_off) >= CAP_BYTES))
        |=> ($stable(ctrl_q) && $stable(num_q) && $stable(sys_q))); // R8
    AST_EFF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (vf_enable && $stable(num_q) && $past(vf_enable)) |-> $stable(eff_vfs)); // R7

endmodule

// File: tb/sriov_cap_regs_tb.sv
module sriov_cap_regs_tb;
    localparam int          OFF_W = 12;
    localparam int          TOTAL = 8;
    localparam int          INIT  = 4;
    localparam logic [15:0] FIRST = 16'h0080;
    localparam logic [15:0] STRD  = 16'h0002;
    localparam logic [15:0] DID   = 16'hA5C3;
    localparam logic [31:0] EXTRA = 32'h0000_2000;
    localparam logic [31:0] SUP   = 32'h0000_0553 | EXTRA;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [OFF_W-1:0] wr_off = '0;
    logic [3:0]       wr_be = '0;
    logic [31:0]      wr_data = '0;
    logic [OFF_W-1:0] rd_off = '0;
    logic [31:0]      rd_data;
    logic [31:0]      extra_pgsz = EXTRA;
    logic             vf_enable, vf_mem_enable, ari_hier, vf_on_pulse, vf_off_pulse;
    logic [15:0]      eff_vfs;

    int errors = 0;
    int checks = 0;

    // bench model state
    logic [7:0]  m_ctrl = 8'h0;
    logic [15:0] m_num  = 16'h0;
    logic [31:0] m_sys  = 32'h1;
    logic        m_on = 1'b0, m_off = 1'b0;

    always #2 clk = ~clk;

    sriov_cap_regs u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_be(wr_be),
        .wr_data(wr_data), .rd_off(rd_off), .rd_data(rd_data), .extra_pgsz(extra_pgsz),
        .vf_enable(vf_enable), .vf_mem_enable(vf_mem_enable), .ari_hier(ari_hier),
        .eff_vfs(eff_vfs), .vf_on_pulse(vf_on_pulse), .vf_off_pulse(vf_off_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [OFF_W-1:0] off);
        if (off >= 12'h40) return 32'h0;
        case (off[OFF_W-1:2])
            10'd2:   return {24'h0, m_ctrl};
            10'd3:   return {16'(TOTAL), 16'(INIT)};
            10'd4:   return {16'h0, m_num};
            10'd5:   return {STRD, FIRST};
            10'd6:   return {DID, 16'h0};
            10'd7:   return SUP;
            10'd8:   return m_sys;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input logic [OFF_W-1:0] off, input logic [3:0] be,
                               input logic [31:0] d);
        logic old_vfe;
        old_vfe = m_ctrl[0];
        if (off < 12'h40) begin
            if (off[OFF_W-1:2] == 10'd2 && be[0]) begin
                m_ctrl = d[7:0] & 8'h19;
                if (m_ctrl[0] && m_num > 16'(TOTAL)) m_ctrl[0] = 1'b0;
            end else if (off[OFF_W-1:2] == 10'd4 && be[1:0] != 2'b00) begin
                if (be[0]) m_num[7:0]  = d[7:0];
                if (be[1]) m_num[15:8] = d[15:8];
                m_ctrl[0] = 1'b0;
            end else if (off[OFF_W-1:2] == 10'd8) begin
                for (int i = 0; i < 4; i++)
                    if (be[i]) m_sys[8*i +: 8] = (m_sys[8*i +: 8] & ~SUP[8*i +: 8])
                                               | (d[8*i +: 8] & SUP[8*i +: 8]);
            end
        end
        m_on  = m_ctrl[0] & ~old_vfe;
        m_off = ~m_ctrl[0] & old_vfe;
    endtask

    task automatic check_outs(input string req);
        check({req, " enable"}, {31'h0, vf_enable}, {31'h0, m_ctrl[0]});
        check({req, " mem/ari"}, {30'h0, vf_mem_enable, ari_hier}, {30'h0, m_ctrl[3], m_ctrl[4]});
        check({req, " eff_vfs"}, {16'h0, eff_vfs}, {16'h0, m_ctrl[0] ? m_num : 16'h0});
        check({req, " pulses"}, {30'h0, vf_on_pulse, vf_off_pulse}, {30'h0, m_on, m_off});
    endtask

    task automatic do_write(input string req, input logic [OFF_W-1:0] off,
                            input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_off = off; wr_be = be; wr_data = d;
        model_write(off, be, d);
        @(negedge clk);
        wr_en = 1'b0;
        check_outs(req);
    endtask

    task automatic do_read(input string req, input logic [OFF_W-1:0] off);
        @(negedge clk);
        rd_off = off;
        @(negedge clk);
        check({req, " read"}, rd_data, exp_read(off));
        m_on = 1'b0; m_off = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [OFF_W-1:0] off;
        logic [31:0]      d;
        int               sel;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state
        check_outs("R3");
        do_read("R3 ctrl", 12'h08);
        do_read("R3 num", 12'h10);
        do_read("R3 sys", 12'h20);
        // R1 only writable bits stick, status half zero
        do_write("R1", 12'h08, 4'hF, 32'hFFFF_FFFF);
        do_read("R1", 12'h08);
        // R5 count write clears enable, with off pulse (R10)
        do_write("R5", 12'h10, 4'h3, 32'hFFFF_0005);
        do_read("R2", 12'h10);
        do_write("R7", 12'h08, 4'h1, 32'h0000_0001);
        check("R7 eff=5", {16'h0, eff_vfs}, 32'h5);
        // R6 over total rejected, equal accepted
        do_write("R6 count9", 12'h10, 4'h1, 32'h9);
        do_write("R6 over", 12'h08, 4'h1, 32'h1);
        check("R6 rejected", {31'h0, vf_enable}, 32'h0);
        do_write("R6 count8", 12'h10, 4'h1, 32'h8);
        do_write("R6 equal", 12'h08, 4'h1, 32'h1);
        check("R6 accepted", {31'h0, vf_enable}, 32'h1);
        // R8 aliased out-of-range writes
        do_write("R8 ctrl alias", 12'h48, 4'hF, 32'h0);
        do_write("R8 num alias", 12'h50, 4'hF, 32'h3);
        do_read("R8 num", 12'h10);
        // R11 lane 0 off at control
        do_write("R11", 12'h08, 4'h2, 32'h0);
        check("R11 still on", {31'h0, vf_enable}, 32'h1);
        // R2 full 16-bit count
        do_write("R2", 12'h10, 4'h3, 32'h0000_ABCD);
        do_read("R2 full", 12'h10);
        // R4 page size mask
        do_write("R4", 12'h20, 4'hF, 32'hFFFF_FFFF);
        do_read("R4 sys", 12'h20);
        do_read("R4 sup", 12'h1C);
        // R9 read-only fields ignore writes
        for (int k = 3; k <= 7; k++) do_write("R9", OFF_W'(4 * k), 4'hF, 32'h0);
        for (int k = 0; k <= 18; k++) do_read("R9", OFF_W'(4 * k));
        // random mix
        for (int n = 0; n < 600; n++) begin
            sel = int'($urandom_range(0, 9));
            d   = $urandom;
            case (sel)
                0, 1, 2: off = 12'h08;
                3, 4:    begin off = 12'h10; d = $urandom_range(0, 11); end
                5:       off = 12'h20;
                6:       off = OFF_W'(4 * $urandom_range(3, 7));
                7:       off = OFF_W'(12'h40 + 4 * $urandom_range(0, 15));
                default: off = OFF_W'(4 * $urandom_range(0, 20));
            endcase
            if (sel == 9) do_read("R9 random", off);
            else do_write("R10 random", off, 4'($urandom_range(0, 15)), d);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule